// File: doc/BRIEF.md
# Piecewise Quadratic Tanh Activation Unit

This unit produces the activation value for one neuron result at a time. It takes a signed Q4.12 operand and a 2-bit activation select. The result is a Q4.12 value for one of three functions: a hyperbolic tangent approximation, the tangent clipped at zero from below, or a rectifier. The tangent is approximated on the operand magnitude by four least-squares quadratics, one per unit interval up to 4.0. Any magnitude beyond 4.0 saturates to exactly 1.0. The sign of a negative operand is put back afterwards by odd symmetry.

The quadratics are evaluated in Horner form, (a·m + b)·m + c. One multiply-round-add datapath is used for both steps, under a small state machine. Coefficients are held in Q2.14, the accumulator runs with 14 fraction bits, and every narrowing step rounds to nearest. A transaction is accepted with a valid/ready handshake and returned the same way. The unit holds one operand at a time.

States:
- `ST_IDLE` waits for `in_valid`. Accepting an operand moves to `ST_SEG`.
- `ST_SEG` selects the segment and latches the magnitude and coefficients. It then takes one of two transitions. The bypass transition goes straight to `ST_DONE`; it applies to rectifier mode, to a negative operand in clipped mode, and to saturation. Otherwise the evaluate transition goes to `ST_MUL1`.
- `ST_MUL1` forms a·m + b and moves to `ST_MUL2`.
- `ST_MUL2` forms the final sum, rounds it, applies sign and mode, and moves to `ST_DONE`.
- `ST_DONE` presents the result until `out_ready`, then returns to `ST_IDLE`.

Top module: `tanh_act_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: In tanh mode (`in_mode` = 2'b00), an operand of magnitude at most 4.0 (raw value within ±16384) gives a result within 0.015 (61 LSB) of the true tanh. Segment k covers magnitudes in (k, k+1]. The value 0 and each boundary belong to the lower segment.
- R3: In tanh mode, an operand of magnitude greater than 4.0 gives exactly +4096 or −4096, following the operand's sign.
- R4: Odd symmetry holds. For any nonzero operand x in tanh mode, result(−x) = −result(x) exactly.
- R5: Clipped mode (`in_mode` = 2'b01) gives max(0, tanh result). Every negative operand, and zero, gives exactly 0.
- R6: Rectifier mode (`in_mode` = 2'b10) gives the operand itself when it is positive, and exactly 0 otherwise.
- R7: `in_mode` = 2'b11 behaves exactly as tanh mode.
- R8: `in_ready` is high only in `ST_IDLE`. `out_valid` rises 4 clock edges after the accepting edge when the quadratic is evaluated. It rises 2 edges after the accepting edge on the bypass transition (rectifier mode, negative operand in clipped mode, or saturation).
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_y` hold unchanged.
- R10: The most negative operand (16'h8000, −8.0) gives exactly −4096 in tanh mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_x | input | 16 | Signed Q4.12 operand |
| in_mode | input | 2 | 00 tanh, 01 clipped tanh, 10 rectifier, 11 tanh |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_y | output | 16 | Signed Q4.12 result |

## Verification
A result is due 4 edges after the accepting edge when a quadratic is evaluated, and 2 edges after it on the bypass transition. The bench counts falling edges from acceptance until `out_valid` appears, and compares that count with the latency the requirement predicts from the operand and mode. Only then does it read `out_y`. During back-pressure it samples on each falling edge, so a change in `out_y` or a premature `in_ready` is seen in the cycle it happens. Tanh values are compared against a real-valued tanh within the stated tolerance. Saturated, clipped and rectified values are compared exactly.

// File: rtl/tanh_act_pkg.sv
package tanh_act_pkg;

    localparam int X_W    = 16;   // operand and result width
    localparam int X_FRAC = 12;   // Q4.12
    localparam int C_W    = 16;   // coefficient width
    localparam int C_FRAC = 14;   // Q2.14
    localparam int ACC_W  = 24;   // Horner accumulator width
    localparam int MAG_W  = X_W + 1;
    localparam int N_SEG  = 4;

    typedef enum logic [1:0] {
        ACT_TANH     = 2'b00,
        ACT_RETANH   = 2'b01,
        ACT_RELU     = 2'b10,
        ACT_TANH_ALT = 2'b11
    } act_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEG,
        ST_MUL1,
        ST_MUL2,
        ST_DONE
    } act_state_e;

    typedef struct packed {
        logic signed [C_W-1:0] a;
        logic signed [C_W-1:0] b;
        logic signed [C_W-1:0] c;
    } quad_coef_t;

    // Least-squares quadratic fits, scaled to Q2.14
    function automatic quad_coef_t seg_coef(input logic [1:0] seg);
        quad_coef_t q;
        unique case (seg)
            2'd0:    q = '{a: -16'sd5366, b: 16'sd17985, c: -16'sd62};
            2'd1:    q = '{a: -16'sd2769, b: 16'sd11503, c: 16'sd3808};
            2'd2:    q = '{a: -16'sd462,  b: 16'sd2790,  c: 16'sd12075};
            default: q = '{a: -16'sd64,   b: 16'sd513,   c: 16'sd15340};
        endcase
        return q;
    endfunction

endpackage

// File: rtl/tanh_seg_sel.sv
module tanh_seg_sel
    import tanh_act_pkg::*;
#(
    parameter int XW   = X_W,
    parameter int FRAC = X_FRAC,
    parameter int NSEG = N_SEG
) (
    input  logic signed [XW-1:0] x,
    output logic [XW:0]          mag,
    output logic                 neg,
    output logic [1:0]           seg,
    output logic                 sat
);
    localparam int MW = XW + 1;

    logic signed [MW-1:0] x_ext;

    always_comb begin
        x_ext = {x[XW-1], x};
        neg   = x[XW-1];
        mag   = neg ? MW'(-x_ext) : MW'(x_ext);
    end

    // Count thresholds exceeded; a boundary value stays in the lower segment
    always_comb begin
        seg = 2'd0;
        for (int k = 1; k < NSEG; k++) begin
            if (mag > MW'(k << FRAC)) seg = seg + 2'd1;
        end
        sat = (mag > MW'(NSEG << FRAC));
    end

endmodule

// File: rtl/tanh_horner_mul.sv
module tanh_horner_mul #(
    parameter int AW   = 24,
    parameter int MW   = 17,
    parameter int FRAC = 12
) (
    input  logic signed [AW-1:0] op,
    input  logic [MW-1:0]        mag,
    input  logic signed [AW-1:0] addend,
    output logic signed [AW-1:0] res
);
    localparam int PW = AW + MW + 1;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);

    logic signed [PW-1:0] op_x;
    logic signed [PW-1:0] mag_x;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;

    always_comb begin
        op_x  = {{(PW-AW){op[AW-1]}}, op};
        mag_x = {{(PW-MW){1'b0}}, mag};
        prod  = op_x * mag_x;
        rnd   = (prod + HALF) >>> FRAC;
        res   = $signed(rnd[AW-1:0]) + addend;
    end

endmodule

// File: rtl/tanh_sign_mode.sv
module tanh_sign_mode
    import tanh_act_pkg::*;
#(
    parameter int XW   = X_W,
    parameter int FRAC = X_FRAC,
    parameter int CF   = C_FRAC,
    parameter int AW   = ACC_W
) (
    input  logic signed [XW-1:0] x,
    input  logic                 neg,
    input  logic                 sat,
    input  act_mode_e            mode,
    input  logic signed [AW-1:0] acc,
    output logic signed [XW-1:0] y
);
    localparam int SH = CF - FRAC;
    localparam logic signed [AW-1:0] RND   = AW'(1) <<< (SH - 1);
    localparam logic signed [XW-1:0] ONE_S = XW'(1) <<< FRAC;

    logic signed [AW-1:0] pr;
    logic signed [XW-1:0] pm;
    logic signed [XW-1:0] ps;

    always_comb begin
        pr = (acc + RND) >>> SH;
        pm = pr[XW-1:0];
        ps = neg ? -pm : pm;
        unique case (mode)
            ACT_RELU:   y = neg ? '0 : x;
            ACT_RETANH: begin
                if (neg)      y = '0;
                else if (sat) y = ONE_S;
                else          y = ps[XW-1] ? '0 : ps;
            end
            default: begin
                if (sat) y = neg ? -ONE_S : ONE_S;
                else     y = ps;
            end
        endcase
    end

endmodule

// File: rtl/tanh_act_unit.sv
module tanh_act_unit
    import tanh_act_pkg::*;
#(
    parameter int XW   = X_W,
    parameter int FRAC = X_FRAC,
    parameter int CW   = C_W,
    parameter int AW   = ACC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [XW-1:0] in_x,
    input  logic [1:0]    in_mode,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [XW-1:0] out_y
);
    localparam int MW = XW + 1;
    localparam logic signed [XW-1:0] ONE_S = XW'(1) <<< FRAC;

    act_state_e           state, state_nx;
    act_mode_e            mode_q;
    logic signed [XW-1:0] x_q;
    logic [MW-1:0]        mag_q;
    quad_coef_t           coef_q;
    logic signed [AW-1:0] acc_q;
    logic signed [XW-1:0] y_q;

    logic [MW-1:0]        mag_c;
    logic                 neg_c;
    logic [1:0]           seg_c;
    logic                 sat_c;
    logic                 bypass;
    logic signed [AW-1:0] mul_op;
    logic signed [AW-1:0] mul_add;
    logic signed [AW-1:0] mul_res;
    logic signed [XW-1:0] y_fin;

    tanh_seg_sel #(.XW(XW), .FRAC(FRAC), .NSEG(N_SEG)) u_seg (
        .x   (x_q),
        .mag (mag_c),
        .neg (neg_c),
        .seg (seg_c),
        .sat (sat_c)
    );

    // Shared multiplier: step 1 uses coefficient a and b, step 2 the accumulator and c
    always_comb begin
        if (state == ST_MUL2) begin
            mul_op  = acc_q;
            mul_add = AW'(coef_q.c);
        end else begin
            mul_op  = AW'(coef_q.a);
            mul_add = AW'(coef_q.b);
        end
    end

    tanh_horner_mul #(.AW(AW), .MW(MW), .FRAC(FRAC)) u_mul (
        .op     (mul_op),
        .mag    (mag_q),
        .addend (mul_add),
        .res    (mul_res)
    );

    tanh_sign_mode #(.XW(XW), .FRAC(FRAC), .CF(C_FRAC), .AW(AW)) u_fin (
        .x    (x_q),
        .neg  (neg_c),
        .sat  (sat_c),
        .mode (mode_q),
        .acc  (mul_res),
        .y    (y_fin)
    );

    always_comb begin
        bypass = (mode_q == ACT_RELU) || sat_c || ((mode_q == ACT_RETANH) && neg_c);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid) state_nx = ST_SEG;
            ST_SEG:  state_nx = bypass ? ST_DONE : ST_MUL1;
            ST_MUL1: state_nx = ST_MUL2;
            ST_MUL2: state_nx = ST_DONE;
            ST_DONE: if (out_ready) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= ACT_TANH;
            x_q    <= '0;
            mag_q  <= '0;
            coef_q <= '0;
            acc_q  <= '0;
            y_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (in_valid) begin
                    x_q    <= in_x;
                    mode_q <= act_mode_e'(in_mode);
                end
                ST_SEG: begin
                    mag_q  <= mag_c;
                    coef_q <= seg_coef(seg_c);
                    if (bypass) y_q <= y_fin;
                end
                ST_MUL1: acc_q <= mul_res;
                ST_MUL2: y_q   <= y_fin;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        in_ready  = (state == ST_IDLE);
        out_valid = (state == ST_DONE);
        out_y     = y_q;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> in_ready && !out_valid) // R1
        else $error("reset state");
    AST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (mode_q != ACT_RELU) |-> ($signed(out_y) <= ONE_S) && ($signed(out_y) >= -ONE_S)) // R2
        else $error("result outside unit range");
    AST_RETANH_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (mode_q == ACT_RETANH) |-> !out_y[XW-1]) // R5
        else $error("clipped result negative");
    AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (mode_q == ACT_RELU) |-> !out_y[XW-1]) // R6
        else $error("rectified result negative");
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready) // R8
        else $error("accepted while busy");
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready) // R8
        else $error("ready while holding result");
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_y)) // R9
        else $error("result changed under back-pressure");

endmodule

// File: tb/tb_tanh_act_unit.sv
`timescale 1ns/1ps
module tb_tanh_act_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_x = '0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_y;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tanh_act_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .in_mode(in_mode), .out_valid(out_valid),
        .out_ready(out_ready), .out_y(out_y)
    );

    localparam int NV = 24;
    localparam logic [17:0] VEC [0:NV-1] = '{
        {2'd0, 16'h0000}, {2'd0, 16'h0001}, {2'd0, 16'h0400}, {2'd0, 16'h1000},
        {2'd0, 16'h1001}, {2'd0, 16'h1800}, {2'd0, 16'h2000}, {2'd0, 16'h2800},
        {2'd0, 16'h3000}, {2'd0, 16'h3800}, {2'd0, 16'h4000}, {2'd0, 16'h4001},
        {2'd0, 16'h7FFF}, {2'd0, 16'hF000}, {2'd0, 16'hD800}, {2'd0, 16'h8000},
        {2'd1, 16'h1800}, {2'd1, 16'hE800}, {2'd1, 16'h0000}, {2'd1, 16'h5000},
        {2'd2, 16'h1234}, {2'd2, 16'hF800}, {2'd2, 16'h0000}, {2'd3, 16'h1800}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // Expected value and latency derived from the requirements
    task automatic expect_of(input logic [1:0] m, input logic [15:0] x,
                             output int e, output bit exact, output int lat, output string req);
        int  xs;
        real xr, t;
        xs = int'($signed(x));
        xr = $itor(xs) / 4096.0;
        exact = 1'b1;
        lat = 2;
        if (m == 2'd2) begin
            e = (xs > 0) ? xs : 0; req = "R6";
        end else if (m == 2'd1 && xs <= 0) begin
            e = 0; req = "R5";
            if (xs == 0) lat = 4;
        end else if (xr > 4.0 || xr < -4.0) begin
            e = (xs < 0) ? -4096 : 4096;
            req = (x == 16'h8000) ? "R10" : "R3";
        end else begin
            t = $tanh(xr);
            if (m == 2'd1 && t < 0.0) t = 0.0;
            e = int'(t * 4096.0);
            exact = 1'b0;
            lat = 4;
            req = (m == 2'd3) ? "R7" : ((m == 2'd1) ? "R5" : "R2");
        end
    endtask

    task automatic do_op(input logic [1:0] m, input logic [15:0] x, input int hold,
                         output int y, output int lat);
        logic [15:0] y0;
        @(negedge clk);
        in_mode = m; in_x = x; in_valid = 1'b1;
        @(posedge clk);
        #1 in_valid = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!out_valid && lat < 20);
        y0 = out_y;
        y = int'($signed(out_y));
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(out_valid && out_y == y0, "R9 hold", int'($signed(out_y)), int'($signed(y0)));
            chk(!in_ready, "R8 ready while busy", int'(in_ready), 0);
        end
        out_ready = 1'b1;
        @(posedge clk);
        #1 out_ready = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int y, lat, e, elat, yp, yn;
        bit exact;
        string req;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!out_valid && in_ready, "R1", int'({out_valid, in_ready}), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && in_ready, "R1", int'({out_valid, in_ready}), 1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            expect_of(VEC[i][17:16], VEC[i][15:0], e, exact, elat, req);
            do_op(VEC[i][17:16], VEC[i][15:0], 0, y, lat);
            if (exact) chk(y == e, req, y, e);
            else       chk((y - e) <= 61 && (e - y) <= 61, req, y, e);
            chk(lat == elat, "R8 latency", lat, elat);
        end

        // R4 odd symmetry
        foreach (VEC[i]) begin
            if (VEC[i][17:16] == 2'd0 && VEC[i][15:0] != 16'h0000 && VEC[i][15:0] != 16'h8000) begin
                do_op(2'd0, VEC[i][15:0], 0, yp, lat);
                do_op(2'd0, 16'(-$signed(VEC[i][15:0])), 0, yn, lat);
                chk(yp == -yn, "R4", yn, -yp);
            end
        end

        // R7 alternate code equals tanh
        do_op(2'd0, 16'h2A00, 0, yp, lat);
        do_op(2'd3, 16'h2A00, 0, yn, lat);
        chk(yp == yn, "R7", yn, yp);

        // R9 back-pressure on both paths
        do_op(2'd0, 16'h1C00, 5, y, lat);
        do_op(2'd2, 16'h0333, 4, y, lat);
        chk(y == 16'h0333, "R6", y, 16'h0333);

        // R1 reset in the middle of an evaluation
        @(negedge clk);
        in_mode = 2'd0; in_x = 16'h1800; in_valid = 1'b1;
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!out_valid && in_ready, "R1 mid-op", int'({out_valid, in_ready}), 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!out_valid && in_ready, "R1 stays idle", int'({out_valid, in_ready}), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule